// File: doc/BRIEF.md
# Single-Frame Byte-Port Network Interface

This peripheral sits on a simple register bus and holds exactly one incoming and one outgoing network frame in two internal byte buffers. An incoming frame arrives as a byte stream with a valid/ready handshake and a last-byte marker. Once the whole frame is in, the block raises a receive-done interrupt. The host then pulls the frame out one byte per read of a data-port register, and a count register shows how many bytes are left.

To transmit, the host programs a length and then writes that many bytes, one per write, into a second data port. The write that brings the total up to the length releases the frame. The block sends it out as a byte stream that waits for downstream ready, and it raises a transmit-done interrupt.

A busy flag decides when a new incoming frame may start. One control register serves three purposes: it holds the interrupt status, it takes acknowledges in a fixed priority order, and it can start a self-test. The self-test clears the block's state and leaves a test interrupt pending. Only the low six address bits are decoded. Read data is combinational in the cycle of the read strobe, and the read side effects take effect at the following clock edge.

Top module: `frame_port_nic`

## Requirements
- R1: After reset the busy register (offset 0x08) reads 1. The receive count (0x0C), the transmit count (0x10) and the interrupt control register (0x14) read 0. `irq` is low and `rx_ready` is low.
- R2: Offset 0x00 reads 0x4D495053 and offset 0x04 reads 0x4E455430. Interrupt info (0x18), the transmit data port (0x20) and every unmapped offset read 0. Address bits above bit 5 are ignored, so 0x40 aliases 0x00.
- R3: A new incoming frame starts only when busy is 0 and the receive count is below MAX_FRAME (1514). `rx_ready` is low otherwise. When the byte marked last is taken, the block does four things: the receive count becomes the frame length, reading restarts at the first byte, busy becomes 1, and bit 1 (receive-done) of interrupt control is set.
- R4: A read of the receive data port (0x1C) while the count is nonzero returns the next byte in the low 8 bits and lowers the count by one. With a zero count the read returns 0 and changes nothing. A frame longer than MAX_FRAME keeps its first MAX_FRAME bytes and loads a count of MAX_FRAME.
- R5: A write to the transmit count stores the value when it is at most MAX_FRAME and stores 0 otherwise. The write also restarts the byte position at 0.
- R6: Each write to the transmit data port stores its low 8 bits as the next byte. The write that makes the byte total equal the count does four things: it releases the frame in write order, it clears the transmit count, it sets bit 0 (transmit-done) of interrupt control, and it sets busy.
- R7: A released frame appears on `tx_data` with `tx_valid` high, one byte per cycle in which `tx_ready` is high. Data and `tx_last` hold while `tx_ready` is low. `tx_last` is high only on the final byte.
- R8: Transmit data-port writes are ignored while the transmit count is 0 and while a released frame is still being sent.
- R9: A write to interrupt control (0x14) is decoded in priority order. Bit 0 set clears transmit-done. Otherwise, bit 1 set clears receive-done. After the write, busy is 1 exactly when interrupt control is nonzero.
- R10: A write to interrupt control with bit 31 set and bits 0 and 1 clear performs a self-test. Both counts and both byte positions clear, any partly received frame is dropped, interrupt control becomes 0x80000000, and busy becomes 1.
- R11: A read of interrupt control returns its current value. The test bit (bit 31) is then cleared.
- R12: `irq` is high exactly when interrupt control is nonzero, and a nonzero interrupt control always comes with busy set.
- R13: Writes to the identifier, busy, receive count, interrupt info and receive data port registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address; only bits 5:0 are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects apply at the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt, high while any interrupt control bit is set |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block takes the incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Downstream takes the outgoing byte |

## Verification
Two situations are the hardest to reach from the ports. The first is the receive gate with the count exactly at its ceiling. The bench streams a frame longer than MAX_FRAME and acknowledges it, so busy is clear while `rx_ready` must stay low. One data-port read then opens the gate. The second is a data-port write that lands while the outgoing stream is still draining. The bench stretches the drain by holding `tx_ready` low two cycles in three, slips a length write and a stray byte in behind the completing write, and then proves from the next frame's contents that the stray byte was dropped.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFS_W  = 6;

    localparam logic [WORD_W-1:0] IDENT_HI = 32'h4D49_5053;
    localparam logic [WORD_W-1:0] IDENT_LO = 32'h4E45_5430;

    localparam int unsigned BIT_TX_DONE = 0;
    localparam int unsigned BIT_RX_DONE = 1;
    localparam int unsigned BIT_TEST    = 31;

    typedef enum logic [3:0] {
        SEL_ID_HI,
        SEL_ID_LO,
        SEL_BUSY,
        SEL_RX_LEN,
        SEL_TX_LEN,
        SEL_IRQ_CTL,
        SEL_IRQ_INFO,
        SEL_RX_PORT,
        SEL_TX_PORT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic test;
        logic rx_done;
        logic tx_done;
    } irq_flags_t;

    typedef struct packed {
        irq_flags_t flags;
        logic       soft_reset;
    } ack_result_t;

    function automatic reg_sel_e decode_offset(input logic [OFS_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            6'h00:   s = SEL_ID_HI;
            6'h04:   s = SEL_ID_LO;
            6'h08:   s = SEL_BUSY;
            6'h0C:   s = SEL_RX_LEN;
            6'h10:   s = SEL_TX_LEN;
            6'h14:   s = SEL_IRQ_CTL;
            6'h18:   s = SEL_IRQ_INFO;
            6'h1C:   s = SEL_RX_PORT;
            6'h20:   s = SEL_TX_PORT;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] flags_to_word(input irq_flags_t f);
        logic [WORD_W-1:0] w;
        w              = '0;
        w[BIT_TEST]    = f.test;
        w[BIT_RX_DONE] = f.rx_done;
        w[BIT_TX_DONE] = f.tx_done;
        return w;
    endfunction

    // Acknowledge decode: lowest set bit of interest wins, test bit last.
    function automatic ack_result_t ack_priority(input irq_flags_t cur,
                                                 input logic [WORD_W-1:0] wv);
        ack_result_t r;
        r.flags      = cur;
        r.soft_reset = 1'b0;
        if (wv[BIT_TX_DONE]) begin
            r.flags.tx_done = 1'b0;
        end else if (wv[BIT_RX_DONE]) begin
            r.flags.rx_done = 1'b0;
        end else if (wv[BIT_TEST]) begin
            r.flags.test    = 1'b1;
            r.flags.rx_done = 1'b0;
            r.flags.tx_done = 1'b0;
            r.soft_reset    = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fpn_byte_ram.sv
module fpn_byte_ram #(
    parameter int unsigned DEPTH  = 1514,
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr <= TOP_ADDR)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (raddr <= TOP_ADDR) ? mem[raddr] : 8'h00;

endmodule

// File: rtl/fpn_rx_store.sv
module fpn_rx_store #(
    parameter int unsigned MAX_BYTES = 1514,
    parameter int unsigned LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_clr,
    input  logic             busy,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             pop,
    output logic             commit,
    output logic [LEN_W-1:0] count,
    output logic [7:0]       head_byte
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BYTES);

    logic             receiving_q;
    logic [LEN_W-1:0] fill_q;
    logic [LEN_W-1:0] count_q;
    logic [LEN_W-1:0] rptr_q;
    logic             take;
    logic             room;
    logic             frame_end;
    logic [LEN_W-1:0] len_now;
    logic [7:0]       ram_byte;

    assign in_ready  = receiving_q || (!busy && (count_q < MAX_L));
    assign take      = in_valid && in_ready;
    assign room      = fill_q < MAX_L;
    assign frame_end = take && in_last;
    assign len_now   = room ? (fill_q + 1'b1) : MAX_L;
    assign commit    = frame_end && !soft_clr;

    fpn_byte_ram #(
        .DEPTH  (MAX_BYTES),
        .ADDR_W (LEN_W)
    ) i_rx_ram (
        .clk   (clk),
        .we    (take && room && !soft_clr),
        .waddr (fill_q),
        .wdata (in_data),
        .raddr (rptr_q),
        .rdata (ram_byte)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            receiving_q <= 1'b0;
            fill_q      <= '0;
            count_q     <= '0;
            rptr_q      <= '0;
        end else begin
            if (take) begin
                if (in_last) begin
                    receiving_q <= 1'b0;
                    fill_q      <= '0;
                end else begin
                    receiving_q <= 1'b1;
                    if (room) begin
                        fill_q <= fill_q + 1'b1;
                    end
                end
            end
            if (frame_end) begin
                count_q <= len_now;
                rptr_q  <= '0;
            end else if (pop && (count_q != '0)) begin
                count_q <= count_q - 1'b1;
                rptr_q  <= rptr_q + 1'b1;
            end
        end
    end

    assign count     = count_q;
    assign head_byte = (count_q != '0) ? ram_byte : 8'h00;

    a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
        count_q <= MAX_L);

    a_r4_pop_steps_down: assert property (@(posedge clk) disable iff (rst)
        (pop && (count_q != '0) && !soft_clr && !frame_end)
        |=> (count_q == $past(count_q) - 1'b1));

    a_r3_commit_loads: assert property (@(posedge clk) disable iff (rst)
        commit |=> ((count_q != '0) && (rptr_q == '0)));

endmodule

// File: rtl/fpn_tx_store.sv
module fpn_tx_store #(
    parameter int unsigned MAX_BYTES = 1514,
    parameter int unsigned LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_clr,
    input  logic             len_wr,
    input  logic [31:0]      len_val,
    input  logic             byte_wr,
    input  logic [7:0]       byte_val,
    output logic [LEN_W-1:0] count,
    output logic             done,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready
);
    localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_BYTES);
    localparam logic [31:0]      LIMIT_W = 32'(MAX_BYTES);

    logic [LEN_W-1:0] count_q;
    logic [LEN_W-1:0] wptr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic             sending_q;
    logic             accept_byte;
    logic             ends;
    logic [LEN_W-1:0] len_clamped;

    assign accept_byte = byte_wr && !sending_q && (count_q != '0);
    assign ends        = accept_byte && ((wptr_q + 1'b1) == count_q);
    assign len_clamped = (len_val <= LIMIT_W) ? len_val[LEN_W-1:0] : '0;
    assign done        = ends && !soft_clr;

    fpn_byte_ram #(
        .DEPTH  (MAX_BYTES),
        .ADDR_W (LEN_W)
    ) i_tx_ram (
        .clk   (clk),
        .we    (accept_byte),
        .waddr (wptr_q),
        .wdata (byte_val),
        .raddr (idx_q),
        .rdata (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            wptr_q  <= '0;
        end else if (soft_clr) begin
            count_q <= '0;
            wptr_q  <= '0;
        end else if (len_wr) begin
            count_q <= len_clamped;
            wptr_q  <= '0;
        end else if (accept_byte) begin
            if (ends) begin
                count_q <= '0;
                wptr_q  <= '0;
            end else begin
                wptr_q <= wptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sending_q <= 1'b0;
            idx_q     <= '0;
            len_q     <= '0;
        end else if (ends) begin
            sending_q <= 1'b1;
            idx_q     <= '0;
            len_q     <= count_q;
        end else if (sending_q && out_ready) begin
            if (out_last) begin
                sending_q <= 1'b0;
                idx_q     <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign count     = count_q;
    assign out_valid = sending_q;
    assign out_last  = sending_q && (idx_q == (len_q - 1'b1));

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        count_q <= MAX_L);

    a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready)
        |=> (out_valid && $stable(out_data) && $stable(out_last)));

    a_r6_release_clears: assert property (@(posedge clk) disable iff (rst)
        done |=> (out_valid && (count_q == '0)));

endmodule

// File: rtl/fpn_ctrl.sv
module fpn_ctrl
    import fpn_pkg::*;
#(
    parameter int unsigned LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              rx_commit,
    input  logic              tx_done,
    input  logic [LEN_W-1:0]  rx_count,
    input  logic [LEN_W-1:0]  tx_count,
    input  logic [7:0]        rx_byte,
    output logic              busy,
    output logic              irq,
    output logic              rx_pop,
    output logic              tx_len_wr,
    output logic              tx_byte_wr,
    output logic              soft_clr
);
    reg_sel_e          sel;
    ack_result_t       ack;
    irq_flags_t        flags_q;
    irq_flags_t        flags_d;
    logic              busy_q;
    logic              busy_d;
    logic              ctl_wr;
    logic              ctl_rd;
    logic [WORD_W-1:0] read_mux;

    assign sel        = decode_offset(bus_ofs);
    assign ack        = ack_priority(flags_q, bus_wdata);
    assign ctl_wr     = bus_wr && (sel == SEL_IRQ_CTL);
    assign ctl_rd     = bus_rd && (sel == SEL_IRQ_CTL);
    assign soft_clr   = ctl_wr && ack.soft_reset;
    assign tx_len_wr  = bus_wr && (sel == SEL_TX_LEN);
    assign tx_byte_wr = bus_wr && (sel == SEL_TX_PORT);
    assign rx_pop     = bus_rd && (sel == SEL_RX_PORT);

    always_comb begin
        flags_d = flags_q;
        if (ctl_wr) begin
            flags_d = ack.flags;
        end
        if (ctl_rd) begin
            flags_d.test = 1'b0;
        end
        if (rx_commit) begin
            flags_d.rx_done = 1'b1;
        end
        if (tx_done) begin
            flags_d.tx_done = 1'b1;
        end
    end

    always_comb begin
        busy_d = busy_q;
        if (ctl_wr) begin
            busy_d = (flags_d != '0);
        end else if (rx_commit || tx_done) begin
            busy_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            busy_q  <= 1'b1;
        end else begin
            flags_q <= flags_d;
            busy_q  <= busy_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_ID_HI:   read_mux = IDENT_HI;
            SEL_ID_LO:   read_mux = IDENT_LO;
            SEL_BUSY:    read_mux = {{(WORD_W-1){1'b0}}, busy_q};
            SEL_RX_LEN:  read_mux = {{(WORD_W-LEN_W){1'b0}}, rx_count};
            SEL_TX_LEN:  read_mux = {{(WORD_W-LEN_W){1'b0}}, tx_count};
            SEL_IRQ_CTL: read_mux = flags_to_word(flags_q);
            SEL_RX_PORT: read_mux = {{(WORD_W-8){1'b0}}, rx_byte};
            default:     read_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? read_mux : '0;
    assign busy      = busy_q;
    assign irq       = (flags_q != '0);

    a_r12_irq_implies_busy: assert property (@(posedge clk) disable iff (rst)
        irq |-> busy_q);

    a_r9_tx_ack_wins: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && bus_wdata[BIT_TX_DONE]) |=> !flags_q.tx_done);

    a_r11_read_drops_test: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && !ctl_wr) |=> !flags_q.test);

    a_r10_selftest_state: assert property (@(posedge clk) disable iff (rst)
        (soft_clr && !ctl_rd)
        |=> (busy_q && flags_q.test && !flags_q.rx_done && !flags_q.tx_done));

endmodule

// File: rtl/frame_port_nic.sv
module frame_port_nic
    import fpn_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 1514,
    parameter int unsigned ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    localparam int unsigned LEN_W = $clog2(MAX_FRAME + 1);

    logic             busy;
    logic             rx_pop;
    logic             rx_commit;
    logic [LEN_W-1:0] rx_count;
    logic [7:0]       rx_byte;
    logic             tx_len_wr;
    logic             tx_byte_wr;
    logic             tx_done;
    logic [LEN_W-1:0] tx_count;
    logic             soft_clr;
    logic             addr_unused_hi;

    assign addr_unused_hi = ^bus_addr[ADDR_W-1:OFS_W];

    fpn_ctrl #(
        .LEN_W (LEN_W)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_ofs    (bus_addr[OFS_W-1:0]),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rx_commit  (rx_commit),
        .tx_done    (tx_done),
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .rx_byte    (rx_byte),
        .busy       (busy),
        .irq        (irq),
        .rx_pop     (rx_pop),
        .tx_len_wr  (tx_len_wr),
        .tx_byte_wr (tx_byte_wr),
        .soft_clr   (soft_clr)
    );

    fpn_rx_store #(
        .MAX_BYTES (MAX_FRAME),
        .LEN_W     (LEN_W)
    ) i_rx (
        .clk       (clk),
        .rst       (rst),
        .soft_clr  (soft_clr),
        .busy      (busy),
        .in_valid  (rx_valid),
        .in_data   (rx_data),
        .in_last   (rx_last),
        .in_ready  (rx_ready),
        .pop       (rx_pop),
        .commit    (rx_commit),
        .count     (rx_count),
        .head_byte (rx_byte)
    );

    fpn_tx_store #(
        .MAX_BYTES (MAX_FRAME),
        .LEN_W     (LEN_W)
    ) i_tx (
        .clk       (clk),
        .rst       (rst),
        .soft_clr  (soft_clr),
        .len_wr    (tx_len_wr),
        .len_val   (bus_wdata),
        .byte_wr   (tx_byte_wr),
        .byte_val  (bus_wdata[7:0]),
        .count     (tx_count),
        .done      (tx_done),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .out_ready (tx_ready)
    );

    a_r1_not_ready_in_reset: assert property (@(posedge clk)
        rst |=> (!rx_ready && !irq));

endmodule

// File: tb/test_frame_port_nic.sv
module test_frame_port_nic;

    localparam int CLK_PERIOD = 10;
    localparam int MAXF       = 1514;

    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] value;
        logic        is_id;
    } rvec_t;

    localparam int NVEC = 13;
    localparam rvec_t RESET_VECS [NVEC] = '{
        '{16'h0000, 32'h4D49_5053, 1'b1},
        '{16'h0004, 32'h4E45_5430, 1'b1},
        '{16'h0008, 32'h0000_0001, 1'b0},
        '{16'h000C, 32'h0000_0000, 1'b0},
        '{16'h0010, 32'h0000_0000, 1'b0},
        '{16'h0014, 32'h0000_0000, 1'b0},
        '{16'h0018, 32'h0000_0000, 1'b1},
        '{16'h001C, 32'h0000_0000, 1'b0},
        '{16'h0020, 32'h0000_0000, 1'b1},
        '{16'h0024, 32'h0000_0000, 1'b1},
        '{16'h003C, 32'h0000_0000, 1'b1},
        '{16'h0040, 32'h4D49_5053, 1'b1},
        '{16'h1048, 32'h0000_0001, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit stall  = 1'b0;
    int cyc    = 0;
    logic [7:0] cap_byte [16];
    logic       cap_last [16];
    int cap_n = 0;

    frame_port_nic i_frame_port_nic (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_last   (rx_last),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        tx_ready <= !stall || ((cyc % 3) == 0);
    end

    always @(negedge clk) begin
        #2;
        if (tx_valid && tx_ready) begin
            if (cap_n < 16) begin
                cap_byte[cap_n] = tx_data;
                cap_last[cap_n] = tx_last;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp,
                          input string req, input string what);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp, what);
    endtask

    task automatic send_frame(input int len, input logic [7:0] base);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = base + 8'(i);
            rx_last  = (i == len - 1);
            forever begin
                #1;
                if (rx_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic wait_caps(input int n);
        for (int i = 0; i < 60; i++) begin
            if (cap_n >= n) break;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(negedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: reset state and fixed registers from the vector table
        check("R1", 32'(irq), 0, "irq after reset");
        check("R1", 32'(rx_ready), 0, "rx_ready after reset");
        for (int i = 0; i < NVEC; i++) begin
            rd_chk(RESET_VECS[i].addr, RESET_VECS[i].value,
                   RESET_VECS[i].is_id ? "R2" : "R1", "reset read");
        end

        // R3: busy blocks, then an all-zero ack clears busy (R9)
        check("R3", 32'(rx_ready), 0, "rx_ready while busy");
        wr(16'h0014, 32'h0);
        rd_chk(16'h0008, 0, "R9", "busy after zero ack");
        #1 check("R3", 32'(rx_ready), 1, "rx_ready when idle");

        // R13: writes to read-only registers
        wr(16'h0008, 32'h1);
        wr(16'h000C, 32'h5);
        wr(16'h0000, 32'h1234_5678);
        wr(16'h001C, 32'hFF);
        rd_chk(16'h0008, 0, "R13", "busy after write");
        rd_chk(16'h000C, 0, "R13", "rx count after write");
        rd_chk(16'h0000, 32'h4D49_5053, "R13", "id after write");

        // R3 / R4: short frame received and read out
        send_frame(5, 8'h10);
        rd_chk(16'h000C, 5, "R3", "rx count after frame");
        rd_chk(16'h0008, 1, "R3", "busy after frame");
        check("R3", 32'(irq), 1, "irq after frame");
        rd_chk(16'h0014, 2, "R3", "rx done bit");
        for (int i = 0; i < 5; i++) begin
            rd_chk(16'h001C, 32'(8'h10 + 8'(i)), "R4", "rx byte");
            rd_chk(16'h000C, 32'(4 - i), "R4", "rx count step");
        end
        rd_chk(16'h001C, 0, "R4", "empty read");
        rd_chk(16'h000C, 0, "R4", "count stays zero");
        #1 check("R3", 32'(rx_ready), 0, "rx_ready blocked by busy");
        wr(16'h0014, 32'h2);
        check("R12", 32'(irq), 0, "irq after rx ack");
        rd_chk(16'h0008, 0, "R9", "busy after rx ack");

        // R4 / R3: oversize frame truncated; full count gates reception
        send_frame(1520, 8'h00);
        rd_chk(16'h000C, MAXF, "R4", "truncated count");
        wr(16'h0014, 32'h2);
        #1 check("R3", 32'(rx_ready), 0, "rx_ready with full count");
        rd_chk(16'h001C, 0, "R4", "first byte of long frame");
        #1 check("R3", 32'(rx_ready), 1, "rx_ready after one pop");
        for (int i = 1; i < MAXF - 1; i++) rd(16'h001C, v);
        rd_chk(16'h001C, 32'(8'((MAXF - 1) & 8'hFF)), "R4", "last kept byte");
        rd_chk(16'h000C, 0, "R4", "count drained");

        // R5 / R8: length clamp and ignored writes
        wr(16'h0010, 32'd2000);
        rd_chk(16'h0010, 0, "R5", "oversize length");
        wr(16'h0020, 32'hAB);
        rd_chk(16'h0010, 0, "R8", "count after write at zero length");
        rd_chk(16'h0014, 0, "R8", "no tx done at zero length");
        check("R8", 32'(cap_n), 0, "no frame at zero length");
        wr(16'h0010, MAXF);
        rd_chk(16'h0010, MAXF, "R5", "max length accepted");
        wr(16'h0010, 32'd4);
        wr(16'h0020, 32'h01);
        wr(16'h0020, 32'h02);
        wr(16'h0010, 32'd3);
        rd_chk(16'h0010, 3, "R5", "reprogrammed length");

        // R6 / R7 / R8: frame under backpressure, stray write while sending
        stall = 1'b1;
        wr(16'h0020, 32'hA1);
        wr(16'h0020, 32'hA2);
        wr(16'h0020, 32'hA3);
        rd_chk(16'h0010, 0, "R6", "tx count cleared on release");
        wr(16'h0010, 32'd2);
        wr(16'h0020, 32'h77);
        rd_chk(16'h0014, 1, "R6", "tx done bit");
        rd_chk(16'h0008, 1, "R6", "busy on release");
        wait_caps(3);
        stall = 1'b0;
        check("R7", 32'(cap_n), 3, "frame length on stream");
        check("R6", 32'(cap_byte[0]), 32'hA1, "tx byte 0");
        check("R6", 32'(cap_byte[1]), 32'hA2, "tx byte 1");
        check("R6", 32'(cap_byte[2]), 32'hA3, "tx byte 2");
        check("R7", 32'({cap_last[0], cap_last[1], cap_last[2]}), 32'b001, "last marker");
        rd_chk(16'h0010, 2, "R8", "length written during send");
        wr(16'h0020, 32'h55);
        wr(16'h0020, 32'h66);
        wait_caps(5);
        check("R8", 32'(cap_byte[3]), 32'h55, "stray byte dropped");
        check("R8", 32'(cap_byte[4]), 32'h66, "second frame byte");
        check("R7", 32'({cap_last[3], cap_last[4]}), 32'b01, "last marker frame 2");

        // R9: acknowledge priority
        wr(16'h0014, 32'h1);
        rd_chk(16'h0008, 0, "R9", "busy after tx ack");
        send_frame(1, 8'hC0);
        wr(16'h0010, 32'd1);
        wr(16'h0020, 32'h3C);
        rd_chk(16'h0014, 3, "R9", "both done bits");
        wr(16'h0014, 32'h3);
        rd_chk(16'h0014, 2, "R9", "tx ack wins over rx ack");
        rd_chk(16'h0008, 1, "R9", "busy with rx done pending");
        wr(16'h0014, 32'h8000_0002);
        rd_chk(16'h0014, 0, "R9", "rx ack wins over test");
        rd_chk(16'h0008, 0, "R9", "busy after last ack");
        check("R12", 32'(irq), 0, "irq with no bits");
        rd_chk(16'h000C, 1, "R9", "no self-test on rx ack");
        wait_caps(6);

        // R10 / R11: self-test
        send_frame(3, 8'hD0);
        wr(16'h0014, 32'h2);
        wr(16'h0010, 32'd5);
        wr(16'h0020, 32'h11);
        wr(16'h0020, 32'h12);
        wr(16'h0014, 32'h8000_0000);
        check("R10", 32'(irq), 1, "irq after self-test");
        rd_chk(16'h0008, 1, "R10", "busy after self-test");
        rd_chk(16'h000C, 0, "R10", "rx count after self-test");
        rd_chk(16'h0010, 0, "R10", "tx count after self-test");
        rd_chk(16'h0014, 32'h8000_0000, "R11", "test bit read");
        rd_chk(16'h0014, 0, "R11", "test bit cleared by read");
        check("R12", 32'(irq), 0, "irq after test bit read");
        rd_chk(16'h0008, 1, "R10", "busy held after read");
        rd_chk(16'h001C, 0, "R10", "rx port empty after self-test");
        wr(16'h0010, 32'd1);
        wr(16'h0020, 32'h99);
        wait_caps(7);
        check("R10", 32'(cap_n), 7, "frame after self-test");
        check("R10", 32'(cap_byte[6]), 32'h99, "tx position restarted");
        check("R7", 32'(cap_last[6]), 1, "single byte last");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule